// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns core-side requests into external-memory bus cycles for a 16-bit address space. The low address byte and the data byte share one 8-bit bus. A separate port carries the high address byte. The external side also has an address-latch strobe, an active-low code-read strobe, and active-low data read and write strobes. One machine cycle is twelve clocks, with one clock standing for one oscillator period. A machine cycle is one of three kinds: a code cycle that fetches two consecutive bytes, a single data read or write, or an idle cycle. The latch strobe keeps a fixed cadence of one pulse every six clocks. A data cycle drops one latch pulse and both code-strobe pulses.

The core offers a request in the last phase of a machine cycle, while `req_ready` is high. The sequencer returns each fetched or read byte as a one-clock pulse on `rsp_valid`, in issue order. The high address byte comes from the request address for code cycles and for data cycles in 16-bit mode. Data cycles in 8-bit mode, and idle cycles, drive the block's own high-port latch instead. The core loads that latch through `p2_load`.

Top module: `xbus_seq`

## Requirements
- R1: A machine cycle is 12 clocks, phases 0 to 11. `req_ready` is high only in phase 11. A request present then (kind 1 fetch, 2 read, 3 write) sets the kind of the next cycle. Otherwise the next cycle is idle.
- R2: In code and idle cycles, `ale` is high in phases 0-1 and 6-7 and low elsewhere. Each pulse is two clocks wide, one pulse per six clocks.
- R3: In read and write cycles, `ale` is high only in phases 0-1. The pulse at phases 6-7 is dropped.
- R4: In a code cycle, `psen_n` is low in phases 3-5 and 9-11. The two bytes are read from the request address and then that address plus one, wrapping at 16 bits, and are returned in that order.
- R5: `psen_n` stays high for the whole of read, write and idle cycles.
- R6: `ad_oe` drives the low address byte in phases 0-2 of every non-idle cycle, and in phases 6-8 of a code cycle. In code and read cycles the bus is released at all other times. In idle cycles it is never driven.
- R7: In a read cycle, `rd_n` is low in phases 5-10: it falls three clocks after `ale` falls and stays low six clocks. `ad_in` is sampled in phase 10 and returned with `rsp_valid` in phase 11.
- R8: In a write cycle, the write byte is driven on `ad_out` in phases 3-11. `wr_n` is low in phases 5-10, so the data is stable before the fall and held one clock after the rise.
- R9: `hi_out` is the upper byte of the address for code cycles (for the second byte, of address plus one) and for data cycles with `req_wide`=1. It is the high-port latch for data cycles with `req_wide`=0 and for idle cycles.
- R10: `p2_load` writes `p2_din` into the high-port latch on the next clock.
- R11: Reset is synchronous and active high. It clears the phase to 0, makes the cycle idle, sets the high-port latch to 8'hFF, holds all active-low strobes high, releases the bus and clears `rsp_valid`.
- R12: `rsp_valid` is a single-clock pulse per returned byte. No byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one oscillator period |
| rst | input | 1 | Synchronous active-high reset |
| req_ready | output | 1 | High in the last phase; request sampled then |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 idle, 1 fetch, 2 read, 3 write |
| req_wide | input | 1 | 1: 16-bit data address, 0: 8-bit |
| req_addr | input | 16 | Code or data address |
| req_wdata | input | 8 | Write byte |
| p2_load | input | 1 | Load the high-port latch |
| p2_din | input | 8 | New high-port latch value |
| rsp_valid | output | 1 | Returned byte valid |
| rsp_data | output | 8 | Returned byte |
| ad_out | output | 8 | Shared bus, outgoing value |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 8 | Shared bus, incoming value |
| hi_out | output | 8 | High address byte |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench runs code cycles at an ordinary address, at an address whose low byte is FF (to show the plus-one carry into the high byte), and at FFFF (to show the 16-bit wrap). It runs wide and narrow writes and reads against a bus memory model. A narrow write followed by a wide read of the same full address proves that the high-port latch supplied the upper byte. Each machine cycle's strobe and drive-enable waveforms are recorded phase by phase and compared with the pattern for the cycle's kind. Back-to-back sequences of mixed kinds, and idle gaps between them, show that a dropped latch pulse belongs only to a data cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_FETCH = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_kind_e;
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase #(
    parameter int CYC_LEN = 12,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;
    assign last  = (phase_q == LAST_PH);

    // R1: the count wraps back to phase 0 after the last phase
    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        last |=> (phase == '0));
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int CYC_LEN = 12,
    parameter int ALE_W   = 2,
    parameter int STB_GAP = 3,
    parameter int STB_W   = 6,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] phase,
    input  cyc_kind_e       kind,
    output logic            ale,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic            addr_slot,
    output logic            second_half,
    output logic            wdrive,
    output logic            smp
);
    localparam int HALF      = CYC_LEN / 2;
    localparam int CODE_LO   = ALE_W + 1;
    localparam int DSTB_FIRST = ALE_W + STB_GAP;
    localparam int DSTB_LAST  = DSTB_FIRST + STB_W - 1;

    always_comb begin
        int p;
        logic in_first_code, in_second_code, in_dstb;
        p = int'(phase);
        in_first_code  = (p >= CODE_LO) && (p < HALF);
        in_second_code = (p >= HALF + CODE_LO) && (p < CYC_LEN);
        in_dstb        = (p >= DSTB_FIRST) && (p <= DSTB_LAST);

        second_half = (p >= HALF);
        ale = (p < ALE_W) ||
              ((p >= HALF) && (p < HALF + ALE_W) &&
               (kind == CYC_FETCH || kind == CYC_IDLE));
        psen_n = !((kind == CYC_FETCH) && (in_first_code || in_second_code));
        rd_n   = !((kind == CYC_READ)  && in_dstb);
        wr_n   = !((kind == CYC_WRITE) && in_dstb);
        addr_slot = ((kind != CYC_IDLE) && (p <= ALE_W)) ||
                    ((kind == CYC_FETCH) && (p >= HALF) && (p <= HALF + ALE_W));
        wdrive = (kind == CYC_WRITE) && (p > ALE_W);
        smp    = ((kind == CYC_FETCH) && (p == HALF - 1 || p == CYC_LEN - 1)) ||
                 ((kind == CYC_READ)  && (p == DSTB_LAST));
    end

    // R7 R8: data strobes are never low together
    assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    // R5: code strobe never overlaps a data strobe
    assert_psen_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> (rd_n && wr_n));
    // R2: latch pulse lasts two clocks
    assert_ale_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale);
    // R7: read strobe falls three clocks after the latch strobe falls
    assert_rd_delay_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> (!$past(ale, 3) && $past(ale, 4)));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int CYC_LEN = 12,
    parameter int ALE_W   = 2,
    parameter int STB_GAP = 3,
    parameter int STB_W   = 6,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              req_ready,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              p2_load,
    input  logic [DATA_W-1:0] p2_din,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n
);
    localparam int PH_W = $clog2(CYC_LEN);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        cyc_kind_e         kind;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [HI_W-1:0]   p2;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } seq_t;

    seq_t s_d, s_q;
    logic [PH_W-1:0]   phase;
    logic              last;
    logic              addr_slot, second_half, wdrive, smp;
    logic [ADDR_W-1:0] cur_addr;

    xbus_phase #(.CYC_LEN(CYC_LEN), .PH_W(PH_W)) u_phase (
        .clk(clk), .rst(rst), .phase(phase), .last(last)
    );

    xbus_strobe_gen #(
        .CYC_LEN(CYC_LEN), .ALE_W(ALE_W), .STB_GAP(STB_GAP),
        .STB_W(STB_W), .PH_W(PH_W)
    ) u_strobe (
        .clk(clk), .rst(rst), .phase(phase), .kind(s_q.kind),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr_slot(addr_slot), .second_half(second_half),
        .wdrive(wdrive), .smp(smp)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        if (p2_load) s_d.p2 = p2_din;
        if (last) begin
            if (req_valid) begin
                s_d.kind  = cyc_kind_e'(req_kind);
                s_d.wide  = req_wide;
                s_d.addr  = req_addr;
                s_d.wdata = req_wdata;
            end else begin
                s_d.kind  = CYC_IDLE;
            end
        end
        if (smp) begin
            s_d.rsp_v = 1'b1;
            s_d.rsp_d = ad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.kind  <= CYC_IDLE;
            s_q.p2    <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cur_addr = (s_q.kind == CYC_FETCH && second_half) ? s_q.addr + 1'b1 : s_q.addr;
        ad_out   = wdrive ? s_q.wdata : cur_addr[DATA_W-1:0];
        ad_oe    = addr_slot || wdrive;
        if (s_q.kind == CYC_FETCH ||
            ((s_q.kind == CYC_READ || s_q.kind == CYC_WRITE) && s_q.wide))
            hi_out = cur_addr[ADDR_W-1:DATA_W];
        else
            hi_out = s_q.p2;
    end

    assign req_ready = last;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_data  = s_q.rsp_d;

    // R7: the shared bus is released while the read strobe is low
    assert_bus_free_on_read_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);
    // R8: the bus is driven while the write strobe is low and one clock after
    assert_write_drive_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);
    assert_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));
    // R12: each returned byte is a single-clock pulse
    assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R5: no code strobe while a data transfer is in its cycle
    assert_no_code_in_data_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> psen_n);
endmodule

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
    logic clk = 0;
    logic rst;
    logic req_ready, req_valid, req_wide, p2_load;
    logic [1:0] req_kind;
    logic [15:0] req_addr;
    logic [7:0] req_wdata, p2_din, rsp_data, ad_out, ad_in, hi_out;
    logic rsp_valid, ad_oe, ale, psen_n, rd_n, wr_n;

    always #4 clk = ~clk;

    xbus_seq u_dut (
        .clk(clk), .rst(rst), .req_ready(req_ready), .req_valid(req_valid),
        .req_kind(req_kind), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .p2_load(p2_load), .p2_din(p2_din),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .hi_out(hi_out), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA7;
    endfunction

    // scoreboard queues
    logic [7:0]  exp_rsp[$];
    string       exp_tag[$];
    logic [23:0] exp_wr[$];
    logic [7:0]  exp_mem[int];
    logic [7:0]  dmem[int];
    logic [7:0]  p2m = 8'hFF;
    logic [1:0]  issued_kind = 2'd0;

    // monitor state
    bit started = 0, prev_ready = 0, prev_ale = 0, prev_wr = 1;
    int ph = 0;
    logic [1:0]  cur_kind = 2'd0;
    logic [11:0] p_ale, p_psen, p_rd, p_wr, p_oe, p_rdy;
    logic [7:0]  lat_lo = 0, lat_hi = 0;

    task automatic close_window();
        logic [11:0] e_ale, e_psen, e_rd, e_wr, e_oe, e_rdy;
        bit data_cyc;
        data_cyc = (cur_kind == 2'd2 || cur_kind == 2'd3);
        for (int i = 0; i < 12; i++) begin
            e_ale[i]  = (i < 2) || (i >= 6 && i < 8 && !data_cyc);
            e_psen[i] = !(cur_kind == 2'd1 && ((i >= 3 && i <= 5) || i >= 9));
            e_rd[i]   = !(cur_kind == 2'd2 && i >= 5 && i <= 10);
            e_wr[i]   = !(cur_kind == 2'd3 && i >= 5 && i <= 10);
            case (cur_kind)
                2'd0: e_oe[i] = 1'b0;
                2'd1: e_oe[i] = (i <= 2) || (i >= 6 && i <= 8);
                2'd2: e_oe[i] = (i <= 2);
                default: e_oe[i] = 1'b1;
            endcase
            e_rdy[i] = (i == 11);
        end
        chk(p_ale == e_ale, data_cyc ? "R3" : "R2", "ale pattern", 32'(p_ale), 32'(e_ale));
        chk(p_psen == e_psen, cur_kind == 2'd1 ? "R4" : "R5", "psen_n pattern", 32'(p_psen), 32'(e_psen));
        chk(p_rd == e_rd, "R7", "rd_n pattern", 32'(p_rd), 32'(e_rd));
        chk(p_wr == e_wr, "R8", "wr_n pattern", 32'(p_wr), 32'(e_wr));
        chk(p_oe == e_oe, "R6", "ad_oe pattern", 32'(p_oe), 32'(e_oe));
        chk(p_rdy == e_rdy, "R1", "req_ready pattern", 32'(p_rdy), 32'(e_rdy));
    endtask

    always @(negedge clk) begin
        if (rst) begin
            started = 0; prev_ready = 0; prev_ale = 0; prev_wr = 1;
            ad_in = 8'h00;
        end else begin
            if (prev_ready) begin
                if (started) close_window();
                started = 1; ph = 0; cur_kind = issued_kind;
                p_ale = '0; p_psen = '0; p_rd = '0; p_wr = '0; p_oe = '0; p_rdy = '0;
            end else if (started) begin
                ph++;
            end
            if (started && ph < 12) begin
                p_ale[ph] = ale; p_psen[ph] = psen_n; p_rd[ph] = rd_n;
                p_wr[ph] = wr_n; p_oe[ph] = ad_oe; p_rdy[ph] = req_ready;
            end
            if (prev_ale && !ale) begin
                lat_lo = ad_out; lat_hi = hi_out;
            end
            if (!prev_wr && wr_n) begin
                if (exp_wr.size() == 0) begin
                    chk(0, "R8", "unexpected write", 32'({lat_hi, lat_lo}), 0);
                end else begin
                    logic [23:0] w;
                    w = exp_wr.pop_front();
                    chk({lat_hi, lat_lo} == w[23:8], "R9", "write address",
                        32'({lat_hi, lat_lo}), 32'(w[23:8]));
                    chk(ad_oe && ad_out == w[7:0], "R8", "write data held",
                        32'({ad_oe, ad_out}), 32'({1'b1, w[7:0]}));
                end
                dmem[int'({lat_hi, lat_lo})] = ad_out;
            end
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) begin
                    chk(0, "R12", "unexpected response", 32'(rsp_data), 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_rsp.pop_front();
                    t = exp_tag.pop_front();
                    chk(rsp_data == e, t, "returned byte", 32'(rsp_data), 32'(e));
                end
            end
            if (!psen_n)
                ad_in = code_byte({lat_hi, lat_lo});
            else if (!rd_n)
                ad_in = dmem.exists(int'({lat_hi, lat_lo})) ? dmem[int'({lat_hi, lat_lo})] : 8'h00;
            else
                ad_in = 8'hEE;
            prev_ready = req_ready; prev_ale = ale; prev_wr = wr_n;
        end
    end

    task automatic wait_ready();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        #1;
    endtask

    task automatic issue(input logic [1:0] k, input logic w, input logic [15:0] a,
                         input logic [7:0] d);
        logic [15:0] full;
        wait_ready();
        req_valid = 1; req_kind = k; req_wide = w; req_addr = a; req_wdata = d;
        issued_kind = k;
        full = w ? a : {p2m, a[7:0]};
        case (k)
            2'd1: begin
                exp_rsp.push_back(code_byte(a));      exp_tag.push_back("R4");
                exp_rsp.push_back(code_byte(a + 1));  exp_tag.push_back("R4");
            end
            2'd2: begin
                exp_rsp.push_back(exp_mem.exists(int'(full)) ? exp_mem[int'(full)] : 8'h00);
                exp_tag.push_back(w ? "R7" : "R9");
            end
            2'd3: begin
                exp_wr.push_back({full, d});
                exp_mem[int'(full)] = d;
            end
            default: ;
        endcase
        @(negedge clk); #1;
        req_valid = 0; issued_kind = 2'd0;
    endtask

    task automatic load_p2(input logic [7:0] v);
        wait_ready();
        p2_load = 1; p2_din = v;
        @(negedge clk); #1;
        p2_load = 0; p2m = v;
        // R10 R9: idle cycle now drives the new latch value
        chk(hi_out == v, "R10", "high latch in idle cycle", 32'(hi_out), 32'(v));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL R1 watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_kind = 0; req_wide = 0; req_addr = 0;
        req_wdata = 0; p2_load = 0; p2_din = 0;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R11: reset state, phase 0 of an idle cycle
        chk(ale == 1, "R11", "ale at phase 0", 32'(ale), 1);
        chk({psen_n, rd_n, wr_n} == 3'b111, "R11", "strobes high", 32'({psen_n, rd_n, wr_n}), 32'h7);
        chk(!ad_oe && !rsp_valid && !req_ready, "R11", "bus/rsp/ready idle",
            32'({ad_oe, rsp_valid, req_ready}), 0);
        chk(hi_out == 8'hFF, "R11", "high latch reset", 32'(hi_out), 32'hFF);

        issue(2'd1, 1'b0, 16'h1234, 8'h00);
        issue(2'd1, 1'b0, 16'h12FF, 8'h00);   // R4 carry into high byte
        issue(2'd1, 1'b0, 16'hFFFF, 8'h00);   // R4 16-bit wrap
        wait_ready();                         // idle gap (R2)
        issue(2'd3, 1'b1, 16'hA55A, 8'h77);
        issue(2'd2, 1'b1, 16'hA55A, 8'h00);
        load_p2(8'h3C);
        issue(2'd3, 1'b0, 16'h0081, 8'h99);   // R9 narrow write lands at 3C81
        issue(2'd2, 1'b0, 16'h0081, 8'h00);
        issue(2'd2, 1'b1, 16'h3C81, 8'h00);   // R9 wide read of same location
        issue(2'd2, 1'b1, 16'h0081, 8'h00);   // R9 distinct location, unwritten
        // back-to-back mixed kinds
        issue(2'd1, 1'b0, 16'h0100, 8'h00);
        issue(2'd3, 1'b1, 16'h0200, 8'h5E);
        issue(2'd2, 1'b1, 16'h0200, 8'h00);
        issue(2'd1, 1'b0, 16'h7F7F, 8'h00);
        load_p2(8'hC3);
        issue(2'd3, 1'b0, 16'h0010, 8'hA1);
        issue(2'd2, 1'b1, 16'hC310, 8'h00);
        repeat (40) @(negedge clk);
        chk(exp_rsp.size() == 0, "R12", "responses outstanding", 32'(exp_rsp.size()), 0);
        chk(exp_wr.size() == 0, "R8", "writes outstanding", 32'(exp_wr.size()), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule